// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block produces the effective address of a load under one of six addressing schemes. A request carries a 3-bit mode, a 32-bit immediate/offset field, a base register number and an index register number. The block reads up to two general-purpose registers through two combinational read ports, and for the auto-stepping schemes it writes the stepped base value back through a single write port. For memory indirection it issues one read on a memory port and waits for the returned word, which becomes the address.

Addresses appear on `ea_addr` with a one-cycle `ea_valid` strobe. A new request is taken only while `busy` is low. `busy` is high only while an indirection read is outstanding.

Top module: `ldaddr_gen`

## Requirements
- R1: Mode 0 (absolute): the effective address equals the full 32-bit `req_imm` field.
- R2: Mode 1 (register-indirect): the effective address equals the base register value, read on port A at index `req_base`.
- R3: Mode 2 (displaced): the effective address equals the base register value plus `req_imm[15:0]` sign-extended to 32 bits, wrapping modulo 2^32.
- R4: Mode 3 (indexed): the effective address equals the base register value plus the index register value (port B, index `req_index`), wrapping modulo 2^32.
- R5: Mode 4 (memory-indirect): in the cycle after acceptance `mem_rd_req` pulses for one cycle with `mem_rd_addr` equal to the base register value. `busy` is high from that cycle until the cycle in which `mem_rd_valid` is seen. `ea_valid` follows one cycle after `mem_rd_valid`, with `ea_addr` equal to `mem_rd_data`.
- R6: Modes 5 (auto-increment) and 6 (auto-decrement): the effective address is the base value before update. In the same cycle as `ea_valid`, `rf_we` is high, `rf_waddr` equals `req_base`, and `rf_wdata` is the base plus or minus the step, wrapping modulo 2^32.
- R7: The auto-mode step is taken from `req_size`: 0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes.
- R8: For every mode except 4, `ea_valid` is a one-cycle pulse in the cycle after the request is accepted. `rf_we` is high only in auto modes.
- R9: A request presented while `busy` is high is ignored. It causes no `ea_valid`, no `rf_we` and no `mem_rd_req`.
- R10: While reset is asserted, `ea_valid`, `busy`, `mem_rd_req` and `rf_we` are low.
- R11: Mode code 7 behaves exactly as absolute mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing mode code |
| req_imm | input | 32 | Immediate; low 16 bits serve as displacement |
| req_base | input | 5 | Base register number |
| req_index | input | 5 | Index register number |
| req_size | input | 2 | Access size code for auto step |
| rf_raddr_a | output | 5 | Register read port A address |
| rf_rdata_a | input | 32 | Register read port A data (combinational) |
| rf_raddr_b | output | 5 | Register read port B address |
| rf_rdata_b | input | 32 | Register read port B data (combinational) |
| rf_we | output | 1 | Base writeback enable |
| rf_waddr | output | 5 | Base writeback register number |
| rf_wdata | output | 32 | Stepped base value |
| mem_rd_req | output | 1 | Indirection read request pulse |
| mem_rd_addr | output | 32 | Indirection read address |
| mem_rd_valid | input | 1 | Indirection read data valid |
| mem_rd_data | input | 32 | Indirection read data |
| ea_valid | output | 1 | Effective address strobe |
| ea_addr | output | 32 | Effective address |
| busy | output | 1 | Indirection read outstanding |

## Verification
The assertions assume that the register file returns data in the same cycle as the address, and that `mem_rd_valid` pulses once per indirection read, no earlier than the cycle after `mem_rd_req`. The bench's register file and memory responder keep to this: the responder waits 1 to 4 cycles after each request. The responder also never drives `mem_rd_valid` while no read is pending. Requests are offered on arbitrary cycles, including while busy, so both acceptance and rejection are exercised.

// File: rtl/ldaddr_gen.sv
module ldaddr_gen #(
  parameter int AW   = 32,
  parameter int RW   = 5,
  parameter int OFFW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] req_imm,
  input  logic [RW-1:0] req_base,
  input  logic [RW-1:0] req_index,
  input  logic [1:0]    req_size,
  output logic [RW-1:0] rf_raddr_a,
  input  logic [AW-1:0] rf_rdata_a,
  output logic [RW-1:0] rf_raddr_b,
  input  logic [AW-1:0] rf_rdata_b,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [AW-1:0] mem_rd_data,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr,
  output logic          busy
);

  localparam logic [2:0] M_ABS  = 3'd0;
  localparam logic [2:0] M_RIND = 3'd1;
  localparam logic [2:0] M_DISP = 3'd2;
  localparam logic [2:0] M_IDX  = 3'd3;
  localparam logic [2:0] M_MIND = 3'd4;
  localparam logic [2:0] M_AINC = 3'd5;
  localparam logic [2:0] M_ADEC = 3'd6;

  logic          waiting;
  logic          take;
  logic          is_auto;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] step;
  logic [AW-1:0] ea_next;

  assign rf_raddr_a = req_base;
  assign rf_raddr_b = req_index;
  assign busy       = waiting;
  assign take       = req_valid && !waiting;
  assign is_auto    = (req_mode == M_AINC) || (req_mode == M_ADEC);
  assign disp_ext   = {{(AW-OFFW){req_imm[OFFW-1]}}, req_imm[OFFW-1:0]};
  assign step       = (req_size == 2'd0) ? AW'(1) :
                      (req_size == 2'd1) ? AW'(2) : AW'(4);

  always_comb begin
    case (req_mode)
      M_RIND, M_AINC, M_ADEC: ea_next = rf_rdata_a;
      M_DISP:                 ea_next = rf_rdata_a + disp_ext;
      M_IDX:                  ea_next = rf_rdata_a + rf_rdata_b;
      default:                ea_next = req_imm;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting     <= 1'b0;
      ea_valid    <= 1'b0;
      ea_addr     <= '0;
      rf_we       <= 1'b0;
      rf_waddr    <= '0;
      rf_wdata    <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      ea_valid   <= 1'b0;
      rf_we      <= 1'b0;
      mem_rd_req <= 1'b0;
      if (waiting) begin
        if (mem_rd_valid) begin
          ea_valid <= 1'b1;
          ea_addr  <= mem_rd_data;
          waiting  <= 1'b0;
        end
      end else if (take) begin
        if (req_mode == M_MIND) begin
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= rf_rdata_a;
          waiting     <= 1'b1;
        end else begin
          ea_valid <= 1'b1;
          ea_addr  <= ea_next;
          if (is_auto) begin
            rf_we    <= 1'b1;
            rf_waddr <= req_base;
            rf_wdata <= (req_mode == M_AINC) ? rf_rdata_a + step : rf_rdata_a - step;
          end
        end
      end
    end
  end

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode != M_MIND) |=> ea_valid);

  assert_mind_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == M_MIND) |=> (mem_rd_req && !ea_valid && busy && mem_rd_addr == $past(rf_rdata_a)));

  assert_mind_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rd_valid) |=> (ea_valid && !busy && ea_addr == $past(mem_rd_data)));

  assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy);

  assert_wb_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ea_valid);

  assert_auto_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_auto) |=> (rf_we && ea_addr == $past(rf_rdata_a) && rf_waddr == $past(req_base)));

  assert_step_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((rf_wdata - ea_addr) inside {AW'(1), AW'(2), AW'(4), -AW'(1), -AW'(2), -AW'(4)}));

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd_valid) |=> (!ea_valid && !rf_we && !mem_rd_req));

endmodule

// File: tb/ldaddr_gen_bench.sv
module ldaddr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [31:0] req_imm = '0;
  logic [4:0]  req_base = '0;
  logic [4:0]  req_index = '0;
  logic [1:0]  req_size = '0;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata;
  logic        rf_we, mem_rd_req, ea_valid, busy;
  logic [31:0] mem_rd_addr, ea_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  logic [31:0] regs [32];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldaddr_gen u_ldaddr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_imm(req_imm), .req_base(req_base), .req_index(req_index), .req_size(req_size),
    .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_b(rf_rdata_b), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .ea_valid(ea_valid), .ea_addr(ea_addr), .busy(busy)
  );

  assign rf_rdata_a = regs[rf_raddr_a];
  assign rf_rdata_b = regs[rf_raddr_b];
  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  // behavioural model state
  bit          m_wait = 0;
  bit          e_valid = 0, e_memreq = 0, e_we = 0;
  logic [31:0] e_addr = 0, e_memaddr = 0, e_wdata = 0;
  logic [4:0]  e_waddr = 0;
  string       e_tag = "R10";
  int          mcnt = 0;
  int          lat_fixed = 0;
  logic [31:0] maddr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] md, input logic [4:0] b,
                      input logic [4:0] x, input logic [31:0] im, input logic [1:0] sz);
    logic [31:0] base, st;
    @(negedge clk);
    chk(ea_valid == e_valid, {e_tag, " ea_valid"}, 32'(ea_valid), 32'(e_valid));
    if (e_valid) chk(ea_addr == e_addr, {e_tag, " ea_addr"}, ea_addr, e_addr);
    chk(busy == m_wait, "R5 busy", 32'(busy), 32'(m_wait));
    chk(mem_rd_req == e_memreq, {e_tag, " mem_rd_req"}, 32'(mem_rd_req), 32'(e_memreq));
    if (e_memreq) chk(mem_rd_addr == e_memaddr, "R5 mem_rd_addr", mem_rd_addr, e_memaddr);
    chk(rf_we == e_we, {e_tag, " rf_we"}, 32'(rf_we), 32'(e_we));
    if (e_we) begin
      chk(rf_waddr == e_waddr, "R6 rf_waddr", 32'(rf_waddr), 32'(e_waddr));
      chk(rf_wdata == e_wdata, "R7 rf_wdata", rf_wdata, e_wdata);
    end
    // memory responder
    mem_rd_valid = 1'b0;
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data = mem_word(maddr);
      end
    end
    if (mem_rd_req) begin
      maddr = mem_rd_addr;
      mcnt = (lat_fixed > 0) ? lat_fixed : int'($urandom_range(1, 4));
    end
    // stimulus
    req_valid = v; req_mode = md; req_base = b; req_index = x; req_imm = im; req_size = sz;
    // model next cycle
    e_valid = 0; e_memreq = 0; e_we = 0;
    base = regs[b];
    st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (m_wait) begin
      if (v) e_tag = "R9";
      if (mem_rd_valid) begin
        e_valid = 1; e_addr = mem_rd_data; m_wait = 0; e_tag = "R5";
      end
    end else if (v) begin
      e_valid = 1;
      case (md)
        3'd1: begin e_addr = base; e_tag = "R2"; end
        3'd2: begin e_addr = base + {{16{im[15]}}, im[15:0]}; e_tag = "R3"; end
        3'd3: begin e_addr = base + regs[x]; e_tag = "R4"; end
        3'd4: begin e_valid = 0; e_memreq = 1; e_memaddr = base; m_wait = 1; e_tag = "R5"; end
        3'd5: begin e_addr = base; e_we = 1; e_waddr = b; e_wdata = base + st; e_tag = "R6"; end
        3'd6: begin e_addr = base; e_we = 1; e_waddr = b; e_wdata = base - st; e_tag = "R6"; end
        3'd7: begin e_addr = im; e_tag = "R11"; end
        default: begin e_addr = im; e_tag = "R1"; end
      endcase
    end else e_tag = "R8";
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R5: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h111;
    regs[3] = 32'hFFFF_FFF0;
    regs[4] = 32'h0000_0000;
    repeat (2) @(negedge clk);
    chk(!ea_valid && !busy && !mem_rd_req && !rf_we, "R10 reset outputs",
        {28'd0, ea_valid, busy, mem_rd_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    step(1, 3'd0, 0, 0, 32'hDEADBEEF, 0);   // R1
    step(1, 3'd1, 7, 0, 32'h0, 0);          // R2
    step(1, 3'd2, 3, 0, 32'h0000_0020, 0);  // R3 wrap
    step(1, 3'd2, 7, 0, 32'h1234_FFFC, 0);  // R3 negative offset
    step(1, 3'd3, 3, 5, 32'h0, 0);          // R4 wrap
    step(0, 3'd0, 0, 0, 32'h0, 0);          // R8 idle
    lat_fixed = 3;
    step(1, 3'd4, 9, 0, 32'h0, 0);          // R5
    step(1, 3'd0, 0, 0, 32'h1111, 0);       // R9 ignored while busy
    step(1, 3'd5, 10, 0, 32'h0, 0);         // R9 ignored while busy
    step(1, 3'd4, 11, 0, 32'h0, 0);         // R9 ignored while busy
    step(1, 3'd1, 2, 0, 32'h0, 0);
    step(0, 3'd0, 0, 0, 32'h0, 0);
    lat_fixed = 0;
    step(1, 3'd5, 10, 0, 32'h0, 0);         // R7 step 1
    step(1, 3'd5, 10, 0, 32'h0, 1);         // R7 step 2
    step(1, 3'd5, 10, 0, 32'h0, 2);         // R7 step 4
    step(1, 3'd5, 10, 0, 32'h0, 3);         // R7 code 3 -> 4
    step(1, 3'd6, 4, 0, 32'h0, 2);          // R6 decrement wraps
    step(1, 3'd6, 4, 0, 32'h0, 0);
    step(1, 3'd7, 0, 0, 32'hCAFE_0001, 0);  // R11
    step(0, 3'd0, 0, 0, 32'h0, 0);
    for (int n = 0; n < 4000; n++)
      step(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
           5'($urandom_range(0, 31)), $urandom, 2'($urandom_range(0, 3)));
    for (int n = 0; n < 8; n++) step(0, 3'd0, 0, 0, 32'h0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule